// File: doc/BRIEF.md
# Double-Buffered Sprite Collision Recorder

The block holds two banks of per-sprite collision entries. At any time one bank belongs to the processor and the other belongs to the renderer. The processor reads and writes its bank one byte at a time. The renderer reports pixel overlaps, and the block folds each report into the entry of the sprite concerned. A single select bit exchanges the two roles. It is sampled only at the frame-start pulse, which stands for scanline -1. At that same pulse the bank that has just become live has its collision status wiped. The sprite's team and depth settings in that bank are kept.

Each entry is 16 bits wide:
- Bits 15..8: the collided sprite ID. The value 0xFF means no sprite collision.
- Bits 7..4: hit flags for background layers 3..0.
- Bit 3: the sprite-collision flag.
- Bit 2: the sprite's team.
- Bits 1..0: the sprite's depth.

An overlap report names two sprites: the owner of the entry to update, and the other sprite. The report also carries a flag that says whether a sprite overlap occurred, plus a 4-bit mask of background layers hit. A sprite overlap counts only if the other sprite has a lower ID than the owner. When team mode is on, the two sprites must also be on different teams. The entry keeps the highest such ID seen during the frame. A separate query port returns the depth and team of any sprite from the live bank. This port works whether or not detection is enabled.

Top module: `sprite_coll_rec`

## Requirements
- R1: After reset every entry of both banks reads 0xFF00, and the select bit is 0.
- R2: When the select bit is 0, bank 0 belongs to the processor; when it is 1, bank 1 does. Address bits are decoded as follows: bit 9 picks the bank, bits 8..1 pick the entry, and bit 0 picks the byte (0 = bits 7..0, 1 = bits 15..8). Reads of the live bank return 0, and writes to the live bank are dropped.
- R3: A change on `frz_req` takes effect only on a cycle with `frame_start` high.
- R4: On `frame_start`, every entry of the new live bank gets ID 0xFF and bits 7..3 cleared. Bits 2..0 are kept.
- R5: Overlap reports are taken only while `det_en` is 1 and `line` is below 240. A report on a `frame_start` cycle is dropped.
- R6: An accepted report ORs `ev_bg` into bits 7..4 of the owner's entry.
- R7: A sprite overlap counts only if `ev_spr` is 1 and `ev_other` is less than `ev_own`. When `team_mode` is 1, bit 2 of the two entries must also differ. A counted overlap sets bit 3.
- R8: On a counted overlap, the ID field takes `ev_other` if the stored ID is 0xFF or is lower than `ev_other`. The field therefore ends the frame holding the highest counted ID.
- R9: With `det_en` at 0, overlap reports leave the live bank unchanged.
- R10: `dq_depth` and `dq_team` return bits 1..0 and bit 2 of live entry `dq_id`, independent of `det_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Collision detection enable |
| team_mode | input | 1 | Count only overlaps between different teams |
| frz_req | input | 1 | Requested processor bank, sampled at frame start |
| frame_start | input | 1 | Pulse marking scanline -1 |
| line | input | 9 | Current scanline |
| ev_valid | input | 1 | Overlap report strobe |
| ev_own | input | 8 | Sprite whose entry is updated |
| ev_other | input | 8 | Other sprite in the overlap |
| ev_spr | input | 1 | A sprite overlap occurred |
| ev_bg | input | 4 | Background layers 3..0 hit |
| cpu_we | input | 1 | Processor byte write strobe |
| cpu_addr | input | 10 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (combinational) |
| dq_id | input | 8 | Sprite for the depth query |
| dq_depth | output | 2 | Depth of the queried sprite |
| dq_team | output | 1 | Team of the queried sprite |

## Verification
The assertions assume the following about the inputs:
- `frame_start` is a single-cycle pulse.
- `frame_start` is low while reset is applied.
- Live-bank IDs come only from clearing and from accepted reports, so a stored ID never exceeds its owner's ID.

The stimulus follows these rules. Overlap reports never fall on a `frame_start` cycle. Processor writes are made only between frame pulses. Each check uses one frame: the live bank is loaded with reports, the banks are swapped to read the result, and they are swapped back. Every row of the vector table therefore starts from a freshly cleared bank.

// File: rtl/sprite_coll_rec.sv
module sprite_coll_rec #(
  parameter int N_SPR     = 256,
  parameter int VIS_LINES = 240,
  parameter int LINE_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en,
  input  logic              team_mode,
  input  logic              frz_req,
  input  logic              frame_start,
  input  logic [LINE_W-1:0] line,
  input  logic              ev_valid,
  input  logic [7:0]        ev_own,
  input  logic [7:0]        ev_other,
  input  logic              ev_spr,
  input  logic [3:0]        ev_bg,
  input  logic              cpu_we,
  input  logic [9:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [7:0]        dq_id,
  output logic [1:0]        dq_depth,
  output logic              dq_team
);
  localparam int IW = 8;
  localparam int EW = IW + 8;
  localparam logic [IW-1:0] NONE = '1;

  logic          frz;
  logic [EW-1:0] mem [2][N_SPR];

  wire live = ~frz;

  wire [EW-1:0] own_e = mem[live][ev_own];
  wire [EW-1:0] oth_e = mem[live][ev_other];
  wire [IW-1:0] old_id = own_e[EW-1:8];

  wire ev_ok = ev_valid && det_en && !frame_start && (line < LINE_W'(VIS_LINES));
  wire spr_hit = ev_spr && (ev_other < ev_own) && (!team_mode || (own_e[2] != oth_e[2]));
  wire id_take = spr_hit && ((old_id == NONE) || (ev_other > old_id));

  wire [EW-1:0] new_e = {id_take ? ev_other : old_id,
                         own_e[7:4] | ev_bg,
                         own_e[3] | spr_hit,
                         own_e[2:0]};

  wire          cb      = cpu_addr[9];
  wire [IW-1:0] ce      = cpu_addr[8:1];
  wire          cpu_hit = (cb == frz);
  wire [EW-1:0] cpu_e   = mem[cb][ce];

  assign cpu_rdata = !cpu_hit ? 8'h00 : (cpu_addr[0] ? cpu_e[15:8] : cpu_e[7:0]);
  assign dq_depth  = mem[live][dq_id][1:0];
  assign dq_team   = mem[live][dq_id][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N_SPR; i++)
          mem[b][i] <= {NONE, 8'h00};
    end else begin
      if (cpu_we && cpu_hit) begin
        if (cpu_addr[0]) mem[cb][ce][15:8] <= cpu_wdata;
        else             mem[cb][ce][7:0]  <= cpu_wdata;
      end
      if (ev_ok) mem[live][ev_own] <= new_e;
      if (frame_start) begin
        frz <= frz_req;
        for (int i = 0; i < N_SPR; i++)
          mem[~frz_req][i][EW-1:3] <= {NONE, 5'b0};
      end
    end
  end

  p_frz_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frz) |-> $past(frame_start));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> (mem[live][dq_id][EW-1:3] == {NONE, 5'b0}));

  p_id_below_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_ok) |-> ((mem[$past(live)][$past(ev_own)][EW-1:8] == NONE) ||
                      (mem[$past(live)][$past(ev_own)][EW-1:8] < $past(ev_own))));

  p_id_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_ok) && ($past(old_id) != NONE)) |->
      (mem[$past(live)][$past(ev_own)][EW-1:8] >= $past(old_id)));

  p_off_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !det_en && !frame_start) |=>
      (mem[$past(live)][$past(ev_own)] == $past(own_e)));
endmodule

// File: tb/tb_sprite_coll_rec.sv
module tb_sprite_coll_rec;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       det_en = 0, team_mode = 0, frz_req = 0, frame_start = 0;
  logic [8:0] line = 0;
  logic       ev_valid = 0, ev_spr = 0;
  logic [7:0] ev_own = 0, ev_other = 0;
  logic [3:0] ev_bg = 0;
  logic       cpu_we = 0;
  logic [9:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic [7:0] dq_id = 0;
  logic [1:0] dq_depth;
  logic       dq_team;

  int n_run = 0, n_fail = 0;

  sprite_coll_rec dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // tm, en, line, own, oa, ob, spr, bg, expected entry
  localparam logic [55:0] VEC [8] = '{
    {1'b0, 1'b1, 9'd10,  8'd10, 8'd3,  8'd7,  1'b1, 4'b0001, 16'h071E}, // R7 R8 R6
    {1'b1, 1'b1, 9'd20,  8'd10, 8'd3,  8'd7,  1'b1, 4'b0000, 16'h030E}, // R7 team filter
    {1'b0, 1'b1, 9'd30,  8'd10, 8'd20, 8'd20, 1'b1, 4'b1000, 16'hFF86}, // R7 higher ID ignored
    {1'b0, 1'b0, 9'd40,  8'd10, 8'd3,  8'd7,  1'b1, 4'b1111, 16'hFF06}, // R9
    {1'b0, 1'b1, 9'd240, 8'd10, 8'd3,  8'd7,  1'b1, 4'b1111, 16'hFF06}, // R5
    {1'b0, 1'b1, 9'd239, 8'd20, 8'd7,  8'd3,  1'b1, 4'b0100, 16'h074B}, // R8 keep max
    {1'b1, 1'b1, 9'd0,   8'd20, 8'd10, 8'd3,  1'b1, 4'b0000, 16'h0A0B}, // R7 team filter
    {1'b0, 1'b1, 9'd100, 8'd3,  8'd7,  8'd20, 1'b0, 4'b0010, 16'hFF21}  // R6 bg only
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd16(input logic bank, input logic [7:0] e, output logic [15:0] v);
    cpu_addr = {bank, e, 1'b0}; #1; v[7:0]  = cpu_rdata;
    cpu_addr = {bank, e, 1'b1}; #1; v[15:8] = cpu_rdata;
  endtask

  task automatic wr8(input logic bank, input logic [7:0] e, input logic hi, input logic [7:0] d);
    cpu_addr = {bank, e, hi}; cpu_wdata = d; cpu_we = 1; step(); cpu_we = 0;
  endtask

  task automatic frame(input logic req);
    frz_req = req; frame_start = 1; step(); frame_start = 0;
  endtask

  task automatic event_in(input logic [7:0] own, input logic [7:0] oth, input logic spr, input logic [3:0] bg);
    ev_own = own; ev_other = oth; ev_spr = spr; ev_bg = bg; ev_valid = 1; step(); ev_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) step();
    rst_n = 1; step();

    rd16(0, 8'd5, v);  check("R1 reset entry", v, 16'hFF00);
    rd16(1, 8'd5, v);  check("R2 live bank reads zero", v, 16'h0000);

    frame(1);
    wr8(1, 8'd3, 0, 8'h01);
    wr8(1, 8'd7, 0, 8'h04);
    wr8(1, 8'd10, 0, 8'h06);
    wr8(1, 8'd20, 0, 8'h03);
    rd16(1, 8'd10, v); check("R2 processor write bank1", v, 16'hFF06);

    frz_req = 0; repeat (3) step();
    rd16(1, 8'd10, v); check("R3 select held without frame pulse", v, 16'hFF06);

    frame(0);
    rd16(1, 8'd10, v); check("R2 bank1 now live reads zero", v, 16'h0000);
    wr8(1, 8'd10, 0, 8'hAA);

    det_en = 0;
    dq_id = 10; #1;
    check("R10 depth query sprite10", {13'd0, dq_team, dq_depth}, 16'h0006);
    dq_id = 20; #1;
    check("R10 depth query sprite20", {13'd0, dq_team, dq_depth}, 16'h0003);

    for (int k = 0; k < 8; k++) begin
      team_mode = VEC[k][55];
      det_en    = VEC[k][54];
      line      = VEC[k][53:45];
      event_in(VEC[k][44:37], VEC[k][36:29], VEC[k][20], VEC[k][19:16]);
      event_in(VEC[k][44:37], VEC[k][28:21], VEC[k][20], VEC[k][19:16]);
      frame(1);
      rd16(1, VEC[k][44:37], v);
      check($sformatf("R4-R9 vector %0d", k), v, VEC[k][15:0]);
      frame(0);
    end

    det_en = 1; line = 10;
    event_in(8'd10, 8'd3, 1'b1, 4'b0011);
    frame(1);
    frame(0);
    frame(1);
    rd16(1, 8'd10, v); check("R4 clear keeps team and depth", v, 16'hFF06);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule